// File: doc/BRIEF.md
# Memory-Mapped Character Terminal Port

This block gives a processor a character terminal that it drives only with ordinary word loads and stores on a simple single-cycle bus. The receive half keeps the most recent character from an external byte source. The transmit half hands one character at a time to an external byte sink over a valid/ready pair. Each half has a control word and a data word. In the control word, bit 0 is a read-only Ready flag and bit 1 is a writable interrupt-enable flag.

Software can poll the Ready flags, or it can set the enable flags and wait for the level interrupt request. That request stays high as long as any enabled half is Ready. The byte source has no back-pressure: every presented character is taken, and a newer one replaces an unread older one.

The receive half is a two-state machine. In RX_EMPTY, an arriving byte causes the transition RX_EMPTY→RX_FULL. In RX_FULL, a data read with no arrival causes RX_FULL→RX_EMPTY, and an arrival keeps the machine in RX_FULL while the byte is replaced. The transmit half is also two states. In TX_IDLE, a data write causes TX_IDLE→TX_BUSY. In TX_BUSY, a sink handshake causes TX_BUSY→TX_IDLE. Writes made while in TX_BUSY are dropped.

Top module: `term_mmio`

## Requirements
- R1: The words are at BASE+0x0 (receive control), BASE+0x4 (receive data), BASE+0x8 (transmit control) and BASE+0xC (transmit data), with BASE = 0xFFFF0000. Any other address, including one with bits 1:0 not zero, reads as zero, and writes to it change nothing.
- R2: A control word reads Ready in bit 0 and interrupt-enable in bit 1. All other bits read as zero.
- R3: A byte presented with `rx_valid` high is taken at that clock edge. From the next cycle the receive Ready is 1, and reading the receive data word returns the byte in bits 7:0 with zeros above.
- R4: A read of the receive data word clears the receive Ready from the next cycle. A read of the receive control word leaves Ready unchanged.
- R5: A byte that arrives while the receive Ready is 1 replaces the held byte. If it arrives in the same cycle as a data read, that read returns the old byte, Ready stays 1, and the new byte is held.
- R6: After reset the transmit Ready is 1. A write to the transmit data word while Ready is 1 puts wdata[7:0] on `tx_data` with `tx_valid` high from the next cycle, and the transmit Ready reads 0.
- R7: `tx_valid` and `tx_data` stay constant until `tx_ready` is sampled high. In the cycle after that handshake, `tx_valid` is 0 and the transmit Ready is 1.
- R8: A write to the transmit data word while the transmit Ready is 0 is ignored.
- R9: A write to a control word sets interrupt-enable from wdata bit 1. Bit 0 and all other bits of the write are ignored.
- R10: `irq` is high exactly when (receive Ready AND receive enable) OR (transmit Ready AND transmit enable).
- R11: After reset both enables are 0, the receive Ready is 0, `tx_valid` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the load or store |
| bus_rd | input | 1 | Load strobe, one cycle |
| bus_wr | input | 1 | Store strobe, one cycle |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid in the cycle of `bus_rd` |
| rx_valid | input | 1 | Incoming byte present (always taken) |
| rx_data | input | 8 | Incoming byte |
| tx_valid | output | 1 | Outgoing byte present |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Sink takes the outgoing byte |
| irq | output | 1 | Level interrupt request |

## Verification
In the receive half, a processor read of the data word and the arrival of a new byte can fall in the same clock cycle. The bench creates this by raising `rx_valid` in the same cycle as a data-word load. It checks three things: the load returns the old byte, the receive Ready still reads 1 afterwards, and a second load returns the new byte. In the transmit half, a store made while a byte is still waiting for the sink is applied against a stalled `tx_ready`, and the bench checks that `tx_data` does not change.

// File: rtl/term_pkg.sv
package term_pkg;
    localparam int READY_BIT = 0;
    localparam int IE_BIT    = 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RX_CTRL,
        SEL_RX_DATA,
        SEL_TX_CTRL,
        SEL_TX_DATA
    } reg_sel_t;

    typedef enum logic {
        RX_EMPTY,
        RX_FULL
    } rx_state_t;

    typedef enum logic {
        TX_IDLE,
        TX_BUSY
    } tx_state_t;
endpackage

// File: rtl/term_decode.sv
module term_decode
    import term_pkg::*;
#(
    parameter int          AW        = 32,
    parameter logic [AW-1:0] BASE_ADDR = 32'hFFFF_0000
) (
    input  logic [AW-1:0] addr,
    output reg_sel_t      sel
);
    localparam int WORD_LSB = 2;
    localparam int SPAN_LSB = 4;

    logic in_window;
    logic aligned;

    assign in_window = (addr[AW-1:SPAN_LSB] == BASE_ADDR[AW-1:SPAN_LSB]);
    assign aligned   = (addr[WORD_LSB-1:0] == '0);

    always_comb begin
        sel = SEL_NONE;
        if (in_window && aligned) begin
            unique case (addr[SPAN_LSB-1:WORD_LSB])
                2'd0: sel = SEL_RX_CTRL;
                2'd1: sel = SEL_RX_DATA;
                2'd2: sel = SEL_TX_CTRL;
                2'd3: sel = SEL_TX_DATA;
            endcase
        end
    end
endmodule

// File: rtl/term_rx.sv
module term_rx
    import term_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [CW-1:0] in_data,
    input  logic          rd_strobe,
    input  logic          ctrl_wr,
    input  logic          ctrl_ie,
    output logic          ready,
    output logic          ie,
    output logic [CW-1:0] held
);
    rx_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (in_valid) state_d = RX_FULL;
            RX_FULL:  if (rd_strobe && !in_valid) state_d = RX_EMPTY;
        endcase
    end

    always_comb begin
        ready = (state_q == RX_FULL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
            ie   <= 1'b0;
        end else begin
            if (in_valid) held <= in_data;
            if (ctrl_wr)  ie   <= ctrl_ie;
        end
    end

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (ready && held == $past(in_data)));
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !in_valid) |=> !ready);
    p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !rd_strobe) |=> ready);
    p_collide_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && in_valid) |=> ready);
endmodule

// File: rtl/term_tx.sv
module term_tx
    import term_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_strobe,
    input  logic [CW-1:0] wr_char,
    input  logic          ctrl_wr,
    input  logic          ctrl_ie,
    input  logic          sink_ready,
    output logic          sink_valid,
    output logic [CW-1:0] sink_data,
    output logic          ready,
    output logic          ie
);
    tx_state_t state_q, state_d;
    logic [CW-1:0] char_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (wr_strobe)  state_d = TX_BUSY;
            TX_BUSY: if (sink_ready) state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        ready      = (state_q == TX_IDLE);
        sink_valid = (state_q == TX_BUSY);
        sink_data  = char_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_q <= '0;
            ie     <= 1'b0;
        end else begin
            if (wr_strobe && state_q == TX_IDLE) char_q <= wr_char;
            if (ctrl_wr) ie <= ctrl_ie;
        end
    end

    p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_strobe) |=> (sink_valid && sink_data == $past(wr_char)));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sink_valid && !sink_ready) |=> (sink_valid && $stable(sink_data)));
    p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sink_valid && sink_ready) |=> (ready && !sink_valid));
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && wr_strobe && !sink_ready) |=> $stable(sink_data));
endmodule

// File: rtl/term_mmio.sv
module term_mmio
    import term_pkg::*;
#(
    parameter int            AW        = 32,
    parameter int            DW        = 32,
    parameter int            CW        = 8,
    parameter logic [AW-1:0] BASE_ADDR = 32'hFFFF_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          rx_valid,
    input  logic [CW-1:0] rx_data,
    output logic          tx_valid,
    output logic [CW-1:0] tx_data,
    input  logic          tx_ready,
    output logic          irq
);
    localparam int PAD_W = DW - CW;

    reg_sel_t      sel;
    logic          rx_rdy, rx_ie, tx_rdy, tx_ie;
    logic [CW-1:0] rx_held;

    term_decode #(.AW(AW), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    term_rx #(.CW(CW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_valid),
        .in_data   (rx_data),
        .rd_strobe (bus_rd && sel == SEL_RX_DATA),
        .ctrl_wr   (bus_wr && sel == SEL_RX_CTRL),
        .ctrl_ie   (bus_wdata[IE_BIT]),
        .ready     (rx_rdy),
        .ie        (rx_ie),
        .held      (rx_held)
    );

    term_tx #(.CW(CW)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_strobe  (bus_wr && sel == SEL_TX_DATA),
        .wr_char    (bus_wdata[CW-1:0]),
        .ctrl_wr    (bus_wr && sel == SEL_TX_CTRL),
        .ctrl_ie    (bus_wdata[IE_BIT]),
        .sink_ready (tx_ready),
        .sink_valid (tx_valid),
        .sink_data  (tx_data),
        .ready      (tx_rdy),
        .ie         (tx_ie)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_RX_CTRL: begin
                bus_rdata[READY_BIT] = rx_rdy;
                bus_rdata[IE_BIT]    = rx_ie;
            end
            SEL_RX_DATA: bus_rdata = {{PAD_W{1'b0}}, rx_held};
            SEL_TX_CTRL: begin
                bus_rdata[READY_BIT] = tx_rdy;
                bus_rdata[IE_BIT]    = tx_ie;
            end
            SEL_TX_DATA: bus_rdata = '0;
            SEL_NONE:    bus_rdata = '0;
        endcase
    end

    always_comb begin
        irq = (rx_rdy && rx_ie) || (tx_rdy && tx_ie);
    end

    p_ie_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_RX_CTRL) |=> (rx_ie == $past(bus_wdata[IE_BIT])));
    p_ie_write_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_TX_CTRL) |=> (tx_ie == $past(bus_wdata[IE_BIT])));
    p_unmapped_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_NONE) |-> (bus_rdata == '0));
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ie && !tx_ie) |-> !irq);
endmodule

// File: tb/term_mmio_test.sv
module term_mmio_test;
    localparam logic [31:0] B = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        irq;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    term_mmio uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks are entered at a falling edge and return at a falling edge.
    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic push(input logic [7:0] c);
        rx_valid = 1'b1; rx_data = c;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 / R6 reset state
        chk("R11 irq", {31'b0, irq}, 0);
        chk("R11 tx_valid", {31'b0, tx_valid}, 0);
        rd(B + 0, d); chk("R11 rx ctrl", d, 0);
        rd(B + 8, d); chk("R6 tx ctrl after reset", d, 1);

        // R9 / R2: only the enable bit is writable
        wr(B + 0, 32'hFFFF_FFFF); rd(B + 0, d); chk("R9 rx ctrl all ones", d, 2);
        wr(B + 0, 32'h1);         rd(B + 0, d); chk("R9 rx ctrl ready bit ignored", d, 0);
        wr(B + 8, 32'hFFFF_FFFD); rd(B + 8, d); chk("R2 tx ctrl enable clear", d, 1);
        wr(B + 8, 32'h2);         rd(B + 8, d); chk("R2 tx ctrl enable set", d, 3);
        wr(B + 8, 32'h0);

        // R1: unmapped and misaligned
        wr(B + 32'h10, 32'h2);  rd(B + 0, d); chk("R1 unmapped write", d, 0);
        wr(32'h0000_000C, 32'h41);
        chk("R1 foreign tx write", {31'b0, tx_valid}, 0);
        push(8'h77);
        rd(B + 32'h5, d);  chk("R1 misaligned read", d, 0);
        rd(B + 32'h10, d); chk("R1 unmapped read", d, 0);
        rd(B + 12, d);     chk("R1 tx data reads zero", d, 0);
        rd(B + 0, d);      chk("R4 ctrl read keeps ready", d, 1);
        rd(B + 0, d);      chk("R4 ready still set", d, 1);
        rd(B + 4, d);      chk("R3 byte", d, 32'h77);
        rd(B + 0, d);      chk("R4 cleared", d, 0);

        // R3 R4 R5 sweep over every byte value, with overwrites on odd values
        for (int v = 0; v < 256; v++) begin
            if (v[0]) push(8'(v ^ 8'hFF));
            push(8'(v));
            rd(B + 0, d); chk("R3 ready after arrival", d, 1);
            rd(B + 4, d); chk(v[0] ? "R5 overwrite" : "R3 data", d, 32'(v));
            rd(B + 0, d); chk("R4 ready cleared", d, 0);
        end

        // R5 collision: arrival in the same cycle as the data read
        for (int k = 0; k < 8; k++) begin
            logic [7:0] a, b;
            a = 8'(8'h11 * k + 3);
            b = 8'(~a);
            push(a);
            rx_valid = 1'b1; rx_data = b;
            bus_addr = B + 4; bus_rd = 1'b1;
            #1 d = bus_rdata;
            @(negedge clk);
            rx_valid = 1'b0; bus_rd = 1'b0;
            chk("R5 collision returns old", d, 32'(a));
            rd(B + 0, d); chk("R5 collision ready kept", d, 1);
            rd(B + 4, d); chk("R5 collision new held", d, 32'(b));
        end

        // R6 R7 R8 sweep over every byte value with varying sink stalls
        for (int v = 0; v < 256; v++) begin
            wr(B + 12, 32'hABCD_0000 | 32'(v));
            chk("R6 tx_valid", {31'b0, tx_valid}, 1);
            chk("R6 tx_data", {24'b0, tx_data}, 32'(v));
            rd(B + 8, d); chk("R6 tx ready low", d, 0);
            wr(B + 12, 32'(v ^ 8'h33));
            chk("R8 busy write ignored", {24'b0, tx_data}, 32'(v));
            for (int s = 0; s < v % 4; s++) begin
                @(negedge clk);
                chk("R7 hold valid", {31'b0, tx_valid}, 1);
                chk("R7 hold data", {24'b0, tx_data}, 32'(v));
            end
            tx_ready = 1'b1;
            @(negedge clk);
            tx_ready = 1'b0;
            chk("R7 valid drops", {31'b0, tx_valid}, 0);
            rd(B + 8, d); chk("R7 ready back", d, 1);
        end

        // R10 sweep: both enables x receive state x transmit state
        for (int m = 0; m < 16; m++) begin
            bit rie, tie, rf, tb;
            rie = m[0]; tie = m[1]; rf = m[2]; tb = m[3];
            wr(B + 0, {30'b0, rie, 1'b1});
            wr(B + 8, {30'b0, tie, 1'b1});
            if (rf) push(8'(m));
            if (tb) wr(B + 12, 32'(m));
            chk("R10 irq", {31'b0, irq}, {31'b0, (rie & rf) | (tie & ~tb)});
            if (rf) rd(B + 4, d);
            if (tb) begin
                tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
            end
            wr(B + 0, 0); wr(B + 8, 0);
            chk("R10 irq off", {31'b0, irq}, 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule